// File: doc/BRIEF.md
# Prescaled Watchdog Timer

A watchdog peripheral on a plain 32-bit memory-mapped register bus. Software sets a clock divider so that the input clock yields one tick per millisecond (the divider holds the number of input clocks per tick, normally the clock rate divided by 1000). It also sets a limit in ticks and starts the timer. While running, a 16-bit elapsed-tick counter climbs once per tick. Software must write the restart register before the counter reaches the limit. If it does not, the block raises a one-cycle system reset request, provided reset generation is enabled, and the counter starts again from zero.

The limit and the live elapsed count share one register word. The limit sits in the low half and can be written. The elapsed count sits in the high half and is read-only. Software therefore gets both values from a single read and works out the remaining time as limit minus elapsed. Ticks need two separate enables, one that gates the clock into the block and one that switches the divider on, as well as the run bit.

Top module: `wdog_timer`

## Requirements
- R1: After synchronous reset the control word reads 0x00000000, the limit word reads 0x00000000 and `rst_req` is low.
- R2: The control word is at byte offset 0x0. Bits 17:0 hold the divider, bit 18 is run, bit 21 enables the reset request, bit 24 is the clock gate and bit 25 is the divider enable. All other bits read zero, so writing 0xFFFFFFFF reads back 0x0327FFFF.
- R3: While bits 24, 25 and 18 are all set, a tick occurs once every D input clocks, where D is the divider value, and a D of 0 acts as 1. If any of those three bits is clear, no tick occurs.
- R4: The elapsed count rises by one on each tick. Clearing bit 18 freezes the count, and setting bit 18 again continues from the frozen value.
- R5: On a tick where elapsed is at or above the limit, the elapsed count becomes zero. If bit 21 is set, `rst_req` is high for exactly the following clock cycle.
- R6: When bit 21 is clear, an expiring tick still zeroes the count, but `rst_req` stays low.
- R7: A write of any data to byte offset 0xC sets the elapsed count to zero. If a tick falls in the same cycle, the restart takes priority: the count ends at zero and no reset request is raised.
- R8: The limit word is at byte offset 0x8. Bits 15:0 are the writable limit. Bits 31:16 read the elapsed count and ignore writes. Writing the limit does not change the elapsed count.
- R9: `bus_rdata` takes the addressed word on the clock edge where `bus_rd` is high and holds that value otherwise. The restart word and unmapped offsets read zero.
- R10: If a new limit is below the current elapsed count, the next tick is an expiring tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| rst_req | output | 1 | System reset request pulse |

## Verification
The bench first runs a set of divider, limit and run-length combinations. It checks both the frozen elapsed count and the number of reset pulses, so an off-by-one in the tick spacing or in the expiry compare shows up as a wrong count or a wrong pulse total. The cases include a divider of zero, a limit of zero (expiry on every tick) and reset generation disabled; a design that pulsed regardless of bit 21 would over-count pulses.

Directed tests then cover the following:
- Freezing and resuming the count: a design that cleared the count on stop would read back too small a value.
- Writing the high half of the limit word: a design that let that write through would corrupt the elapsed count.
- Lowering the limit below the count: an equality-only compare would never expire.
- A restart in the same cycle as a tick: a design that gave the tick priority would leave a non-zero count.
- Read data holding between reads.

// File: rtl/wdog_pkg.sv
// Package: shared register offsets and control bit positions of the watchdog.
// Assumes a byte-addressed bus with word-aligned registers.
package wdog_pkg;
    localparam int OFS_CTRL  = 'h0;
    localparam int OFS_LIMIT = 'h8;
    localparam int OFS_KICK  = 'hC;

    localparam int BIT_RUN    = 18;
    localparam int BIT_REQEN  = 21;
    localparam int BIT_CLKON  = 24;
    localparam int BIT_PREDIV = 25;

    localparam int ELAPSED_LSB = 16;   // elapsed count position in the limit word
endpackage

// File: rtl/wdog_prescaler.sv
// wdog_prescaler: turns the input clock into a tick every DIV input clocks.
// Assumes a divider of 0 or 1 means a tick every clock. The phase counter is
// held at zero while inactive, so each start begins a whole tick period.
module wdog_prescaler #(
    parameter int DIV_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;
    logic             last;

    // Decide whether this clock closes a tick period.
    always_comb begin
        last = (div <= DIV_W'(1)) || (phase_q >= (div - DIV_W'(1)));
        tick = active && last;
    end

    // Advance the phase, wrap at period end, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (!active || last)
            phase_q <= '0;
        else
            phase_q <= phase_q + DIV_W'(1);
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (div > DIV_W'(1))) |=> (!tick || (div != $past(div)))); // R3
endmodule

// File: rtl/wdog_counter.sv
// wdog_counter: elapsed tick counter with expiry detection and reset request.
// Assumes tick is already gated by the run enable. A restart wins over a
// same-cycle tick. Expiry uses >= so a lowered limit fires on the next tick.
module wdog_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             kick,
    input  logic [CNT_W-1:0] limit,
    input  logic             req_en,
    output logic [CNT_W-1:0] elapsed,
    output logic             rst_req
);
    logic hit;

    // An expiring tick: elapsed already at or past the limit.
    always_comb hit = tick && (elapsed >= limit);

    // Elapsed count: restart, wrap on expiry, or step on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            elapsed <= '0;
        else if (kick || hit)
            elapsed <= '0;
        else if (tick)
            elapsed <= elapsed + CNT_W'(1);
    end

    // Reset request: one cycle after an expiring tick when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_req <= 1'b0;
        else
            rst_req <= hit && req_en && !kick;
    end

    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (elapsed == '0)); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !kick) |=> $stable(elapsed)); // R4
    AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !kick && (elapsed < limit)) |=> (elapsed == $past(elapsed) + CNT_W'(1))); // R4
    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !kick && (elapsed >= limit)) |=> ((elapsed == '0) && (rst_req == $past(req_en)))); // R5
    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(tick && req_en && !kick)); // R6
endmodule

// File: rtl/wdog_regs.sv
// wdog_regs: decodes the register bus, holds control and limit, issues the
// restart strobe and drives registered read data.
// Assumes word-aligned accesses; byte lanes are not supported.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DIV_W  = 18,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic [CNT_W-1:0]  elapsed,
    output logic [DIV_W-1:0]  div,
    output logic              run,
    output logic              req_en,
    output logic              clk_on,
    output logic              prediv_on,
    output logic [CNT_W-1:0]  limit,
    output logic              kick
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] W_CTRL  = WORD_W'(OFS_CTRL  >> 2);
    localparam logic [WORD_W-1:0] W_LIMIT = WORD_W'(OFS_LIMIT >> 2);
    localparam logic [WORD_W-1:0] W_KICK  = WORD_W'(OFS_KICK  >> 2);

    logic [WORD_W-1:0] word;
    logic              sel_ctrl, sel_limit, sel_kick;
    logic [31:0]       rd_mux;
    logic              unused_bits;

    // Word decode of the byte address.
    always_comb begin
        word      = bus_addr[ADDR_W-1:2];
        sel_ctrl  = (word == W_CTRL);
        sel_limit = (word == W_LIMIT);
        sel_kick  = (word == W_KICK);
        kick      = bus_wr && sel_kick;
    end

    // Bits of the bus that no register stores.
    assign unused_bits = ^{bus_addr[1:0], bus_wdata};

    // Control register fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div       <= '0;
            run       <= 1'b0;
            req_en    <= 1'b0;
            clk_on    <= 1'b0;
            prediv_on <= 1'b0;
        end else if (bus_wr && sel_ctrl) begin
            div       <= bus_wdata[DIV_W-1:0];
            run       <= bus_wdata[BIT_RUN];
            req_en    <= bus_wdata[BIT_REQEN];
            clk_on    <= bus_wdata[BIT_CLKON];
            prediv_on <= bus_wdata[BIT_PREDIV];
        end
    end

    // Limit field; the elapsed half of the word is not writable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit <= '0;
        else if (bus_wr && sel_limit)
            limit <= bus_wdata[CNT_W-1:0];
    end

    // Read multiplexer; unlisted bits and words return zero.
    always_comb begin
        rd_mux = '0;
        if (sel_ctrl) begin
            rd_mux[DIV_W-1:0]  = div;
            rd_mux[BIT_RUN]    = run;
            rd_mux[BIT_REQEN]  = req_en;
            rd_mux[BIT_CLKON]  = clk_on;
            rd_mux[BIT_PREDIV] = prediv_on;
        end else if (sel_limit) begin
            rd_mux[CNT_W-1:0]               = limit;
            rd_mux[ELAPSED_LSB +: CNT_W]    = elapsed;
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R9
    AST_LIMIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel_limit) |=> (limit == $past(bus_wdata[CNT_W-1:0]))); // R8
endmodule

// File: rtl/wdog_timer.sv
// wdog_timer: top of the memory-mapped watchdog. Wires the register block,
// the tick prescaler and the elapsed counter.
// Assumes DIV_W <= 18 and CNT_W <= 16 so the fields fit the fixed bit map.
module wdog_timer #(
    parameter int ADDR_W = 4,
    parameter int DIV_W  = 18,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              rst_req
);
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] limit, elapsed;
    logic             run, req_en, clk_on, prediv_on, kick;
    logic             active, tick;

    // Ticks need the clock gate, the divider enable and run together.
    assign active = clk_on && prediv_on && run;

    wdog_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .elapsed(elapsed), .div(div), .run(run), .req_en(req_en),
        .clk_on(clk_on), .prediv_on(prediv_on), .limit(limit), .kick(kick)
    );

    wdog_prescaler #(.DIV_W(DIV_W)) pre_i (
        .clk(clk), .rst_n(rst_n), .active(active), .div(div), .tick(tick)
    );

    wdog_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .limit(limit),
        .req_en(req_en), .elapsed(elapsed), .rst_req(rst_req)
    );

    AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(active)); // R3
endmodule

// File: tb/wdog_timer_tb.sv
// Bench for wdog_timer: a table of run vectors, then directed corner tests.
module wdog_timer_tb_top;
    localparam logic [31:0] EN_BITS = 32'h0304_0000;  // bits 25,24,18
    localparam logic [31:0] GATE_ON = 32'h0300_0000;  // bits 25,24
    localparam logic [31:0] REQ_BIT = 32'h0020_0000;  // bit 21

    typedef struct packed {
        logic [17:0] dv;
        logic [15:0] lim;
        logic [7:0]  idle;
        logic        ren;
        logic [15:0] ecnt;
        logic [7:0]  epul;
    } vec_t;

    // Elapsed after T=floor((idle+1)/max(dv,1)) ticks is T mod (lim+1).
    localparam vec_t VECS [8] = '{
        '{18'd1, 16'd10,     8'd4,  1'b1, 16'd5,  8'd0},
        '{18'd1, 16'd3,      8'd9,  1'b1, 16'd2,  8'd2},
        '{18'd3, 16'd100,    8'd11, 1'b1, 16'd4,  8'd0},
        '{18'd4, 16'd2,      8'd22, 1'b1, 16'd2,  8'd1},
        '{18'd0, 16'd5,      8'd6,  1'b1, 16'd1,  8'd1},
        '{18'd2, 16'd1,      8'd9,  1'b0, 16'd1,  8'd0},
        '{18'd5, 16'd0,      8'd14, 1'b1, 16'd0,  8'd3},
        '{18'd1, 16'hFFFF,   8'd49, 1'b1, 16'd50, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    wdog_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .rst_req(rst_req)
    );

    always @(negedge clk) if (rst_n && rst_req) pulses++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 rst_req", {31'd0, rst_req}, 32'd0);
        rd(4'h0, rv); chk("R1 ctrl", rv, 32'h0);
        rd(4'h8, rv); chk("R1 limit", rv, 32'h0);

        // R3 R4 R5 R6: table of run vectors
        foreach (VECS[i]) begin
            wr(4'hC, 32'h1234_5678);
            pulses = 0;
            wr(4'h8, {16'd0, VECS[i].lim});
            wr(4'h0, EN_BITS | (VECS[i].ren ? REQ_BIT : 32'd0) | {14'd0, VECS[i].dv});
            idle(int'(VECS[i].idle));
            wr(4'h0, GATE_ON | {14'd0, VECS[i].dv});
            rd(4'h8, rv);
            chk("R4 vector elapsed", {16'd0, rv[31:16]}, {16'd0, VECS[i].ecnt});
            chk("R8 vector limit", {16'd0, rv[15:0]}, {16'd0, VECS[i].lim});
            chk(VECS[i].ren ? "R5 vector pulses" : "R6 vector pulses", pulses, {24'd0, VECS[i].epul});
        end

        // R4: freeze and resume
        wr(4'hC, 32'd0);
        wr(4'h0, EN_BITS | REQ_BIT | 32'd1);
        idle(4);
        wr(4'h0, GATE_ON | REQ_BIT | 32'd1);
        rd(4'h8, rv); chk("R4 stopped", {16'd0, rv[31:16]}, 32'd5);
        idle(5);
        rd(4'h8, rv); chk("R4 frozen", {16'd0, rv[31:16]}, 32'd5);
        wr(4'h0, EN_BITS | REQ_BIT | 32'd1);
        idle(2);
        wr(4'h0, GATE_ON | REQ_BIT | 32'd1);
        rd(4'h8, rv); chk("R4 resumed", {16'd0, rv[31:16]}, 32'd8);

        // R8: upper half of limit word ignores writes, count kept
        wr(4'h8, 32'hABCD_0007);
        rd(4'h8, rv); chk("R8 readonly elapsed", rv, 32'h0008_0007);

        // R10: limit below count expires on next tick
        pulses = 0;
        wr(4'h0, EN_BITS | REQ_BIT | 32'd1);
        wr(4'h0, GATE_ON | REQ_BIT | 32'd1);
        rd(4'h8, rv); chk("R10 wrapped", rv, 32'h0000_0007);
        chk("R10 pulse", pulses, 32'd1);

        // R3: missing clock gate or divider enable stops ticks
        wr(4'hC, 32'd0);
        wr(4'h8, 32'h0000_FFFF);
        wr(4'h0, 32'h0204_0001);
        idle(10);
        wr(4'h0, 32'h0104_0001);
        idle(10);
        wr(4'h0, 32'h0);
        rd(4'h8, rv); chk("R3 gated", rv, 32'h0000_FFFF);

        // R7: restart beats a same-cycle tick
        wr(4'h0, EN_BITS | 32'd1);
        idle(3);
        wr(4'hC, 32'hDEAD_BEEF);
        wr(4'h0, GATE_ON | 32'd1);
        rd(4'h8, rv); chk("R7 kick priority", rv, 32'h0001_FFFF);

        // R9: read data holds, restart word reads zero
        idle(2);
        chk("R9 hold", bus_rdata, 32'h0001_FFFF);
        rd(4'hC, rv); chk("R9 kick reads zero", rv, 32'h0);
        rd(4'h4, rv); chk("R9 unmapped zero", rv, 32'h0);

        // R2: unused control bits read zero
        wr(4'h0, 32'hFFFF_FFFF);
        wr(4'h0, 32'hFFFB_FFFF);
        rd(4'h0, rv); chk("R2 ctrl mask", rv, 32'h0323_FFFF);
        wr(4'h0, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung, expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule